// File: doc/BRIEF.md
# Output Shutdown Protection Controller

This block guards a power stage. It watches nine active-low fault inputs and the six outputs of three complementary PWM pairs. When it sees a fault, it raises registered high-impedance enables for three groups of timer output pins. Two of the groups are high-current pins. The third is the four outputs of timer channel 0. The pad drivers act on these enables and are not part of the block.

Each fault input has its own detection mode. It can detect a falling edge. It can also require a run of consecutive low samples taken at one of three divided clock rates. Every detection sets a sticky flag. A flag can feed its group's high-impedance enable and an interrupt request. A comparator checks the registered PWM outputs. If both outputs of a pair are at their active level at once, which would cause shoot-through, it sets its own sticky flag. Software can force the high-current groups or the channel-0 group into high impedance through the control register.

Configuration goes through a small word port. The port has three addresses, and read data arrives one cycle after the read strobe.

Top module: `shutdown_guard`

## Requirements
- R1: After synchronous reset, all three high-impedance enables and both interrupt requests are low. The MODE (address 0), CTRL (address 1) and FLAGS (address 2) registers all read as zero.
- R2: MODE holds two bits per input. Input i uses bits [2i+1:2i]. The codes are: 00 falling edge, 01 low-level sampling at clk/8, 10 at clk/16, 11 at clk/128. One free-running divider, started at reset, paces all the inputs.
- R3: In a sampling mode with divide D, the input's flag sets only when 16 consecutive samples read low. Any high sample restarts the count. Take a pin that goes low before clock edge 1 and stays low. Its group enable is still low after edge 3+15·D and is high after edge 3+16·D. A low pulse of 15·D cycles sets nothing.
- R4: In edge mode, a falling edge on a pin sets its flag through a two-stage synchronizer. For a pin that falls before edge 1, the group enable and the interrupt are low after edge 3 and high after edge 4. A pin held low does not set the flag again after the flag is cleared.
- R5: CTRL[8:0] gates each input's effect on the enables. Inputs 0–3 drive group A (hiz_hca). Inputs 4–7 drive group B (hiz_hcb). Input 8 drives the channel-0 group (hiz_ch0). A flag sets whatever its gate bit says. An enable follows its contributing flags one cycle later and stays high while any of them is set.
- R6: Pair k is formed by pwm_mon[2k] and pwm_mon[2k+1]. CTRL[11+k] sets its active level (1 = high). CTRL[14] turns the comparator on. If both outputs of a pair are active at a clock edge, FLAGS[9] sets at the next edge and both high-current enables rise one edge after that. With CTRL[14] clear, nothing happens.
- R7: Flags are sticky. A flag bit clears only when a write of 0 to FLAGS follows a read of FLAGS that returned that bit as 1. A write of 0 with no such read does nothing. A write of 1 does nothing and also cancels the pending read.
- R8: CTRL[15] forces both high-current enables high, and CTRL[16] forces the channel-0 enable high. Each enable changes one cycle after the write edge.
- R9: irq_fault is CTRL[9] AND any input flag. irq_short is CTRL[10] AND FLAGS[9]. Both are registered one cycle after the flags.
- R10: cfg_rdata is registered and is valid one cycle after cfg_re. MODE and CTRL read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_n | input | 9 | Active-low fault inputs, asynchronous |
| pwm_mon | input | 6 | Outputs of the complementary PWM pairs |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after cfg_re |
| hiz_hca | output | 1 | High-impedance enable, high-current group A |
| hiz_hcb | output | 1 | High-impedance enable, high-current group B |
| hiz_ch0 | output | 1 | High-impedance enable, channel-0 group |
| irq_fault | output | 1 | Interrupt request from input detection |
| irq_short | output | 1 | Interrupt request from pair comparison |

## Verification
For an edge fault, the enable is due four edges after the pin falls: two synchronizer stages, the flag, then the output register. A comparator overlap shows up three edges after it is driven, and a software force or a flag clear shows up one edge after the write. The bench drives at falling clock edges and samples one cycle before each due edge and at it. This pins every latency exactly. In the sampling modes the divider phase shifts detection by up to D cycles. So the bench checks the bounds in R3, 3+15·D edges (still low) and 3+16·D edges (high), for each of the three rates.

// File: rtl/shg_pkg.sv
package shg_pkg;

  typedef enum logic [1:0] {
    DET_EDGE  = 2'd0,
    DET_DIV_A = 2'd1,
    DET_DIV_B = 2'd2,
    DET_DIV_C = 2'd3
  } det_mode_e;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_FLAGS = 2'd2;

endpackage

// File: rtl/shg_prescale.sv
module shg_prescale #(
  parameter int DIV_A = 8,
  parameter int DIV_B = 16,
  parameter int DIV_C = 128
) (
  input  logic clk,
  input  logic rst,
  output logic tick_a,
  output logic tick_b,
  output logic tick_c
);
  localparam int CNT_W = $clog2(DIV_C);
  localparam logic [CNT_W-1:0] MASK_A = CNT_W'(DIV_A - 1);
  localparam logic [CNT_W-1:0] MASK_B = CNT_W'(DIV_B - 1);
  localparam logic [CNT_W-1:0] MASK_C = CNT_W'(DIV_C - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CNT_W'(1);
  end

  assign tick_a = (cnt & MASK_A) == MASK_A;
  assign tick_b = (cnt & MASK_B) == MASK_B;
  assign tick_c = (cnt & MASK_C) == MASK_C;

endmodule

// File: rtl/shg_fault_det.sv
module shg_fault_det
  import shg_pkg::*;
#(
  parameter int RUN_LEN = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_n,
  input  det_mode_e mode,
  input  logic      tick_a,
  input  logic      tick_b,
  input  logic      tick_c,
  output logic      det
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN - 1);

  logic             sync1, sync2, prev;
  logic [RUN_W-1:0] run;
  logic             sel_tick, edge_hit, lvl_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      prev  <= 1'b1;
    end else begin
      sync1 <= pin_n;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_comb begin
    case (mode)
      DET_DIV_A: sel_tick = tick_a;
      DET_DIV_B: sel_tick = tick_b;
      DET_DIV_C: sel_tick = tick_c;
      default:   sel_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || mode == DET_EDGE) begin
      run <= '0;
    end else if (sel_tick) begin
      if (sync2)               run <= '0;
      else if (run != RUN_MAX) run <= run + RUN_W'(1);
    end
  end

  assign edge_hit = (mode == DET_EDGE) && prev && !sync2;
  assign lvl_hit  = (mode != DET_EDGE) && sel_tick && !sync2 && (run == RUN_MAX);
  assign det      = edge_hit || lvl_hit;

  AST_RUN_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    run != $past(run) |-> (run == '0) || (run == $past(run) + RUN_W'(1))); // R3

  AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (mode == DET_EDGE) && det |=> !det); // R4

endmodule

// File: rtl/shg_pair_cmp.sv
module shg_pair_cmp #(
  parameter int NUM_PAIRS = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*NUM_PAIRS-1:0] pwm,
  input  logic [NUM_PAIRS-1:0]   pol,
  input  logic                   en,
  output logic                   hit
);
  logic [2*NUM_PAIRS-1:0] pwm_q;
  logic [NUM_PAIRS-1:0]   pair_hit;

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= '0;
    else     pwm_q <= pwm;
  end

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    logic act_lo, act_hi;
    assign act_lo      = pwm_q[2*k]   ~^ pol[k];
    assign act_hi      = pwm_q[2*k+1] ~^ pol[k];
    assign pair_hit[k] = act_lo && act_hi;
  end

  assign hit = en && (|pair_hit);

endmodule

// File: rtl/shutdown_guard.sv
module shutdown_guard
  import shg_pkg::*;
#(
  parameter int NUM_IN    = 9,
  parameter int NUM_PAIRS = 3,
  parameter int RUN_LEN   = 16,
  parameter int DIV_A     = 8,
  parameter int DIV_B     = 16,
  parameter int DIV_C     = 128,
  parameter int DATA_W    = 32,
  parameter logic [NUM_IN-1:0] GRP_A_MASK = 9'h00F,
  parameter logic [NUM_IN-1:0] GRP_B_MASK = 9'h0F0,
  parameter logic [NUM_IN-1:0] GRP_C_MASK = 9'h100
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_IN-1:0]      fault_n,
  input  logic [2*NUM_PAIRS-1:0] pwm_mon,
  input  logic                   cfg_we,
  input  logic                   cfg_re,
  input  logic [1:0]             cfg_addr,
  input  logic [DATA_W-1:0]      cfg_wdata,
  output logic [DATA_W-1:0]      cfg_rdata,
  output logic                   hiz_hca,
  output logic                   hiz_hcb,
  output logic                   hiz_ch0,
  output logic                   irq_fault,
  output logic                   irq_short
);
  localparam int MODE_W    = 2 * NUM_IN;
  localparam int CTL_IEI   = NUM_IN;
  localparam int CTL_IEC   = NUM_IN + 1;
  localparam int CTL_POL   = NUM_IN + 2;
  localparam int CTL_CMPEN = CTL_POL + NUM_PAIRS;
  localparam int CTL_SWHC  = CTL_CMPEN + 1;
  localparam int CTL_SWCH0 = CTL_SWHC + 1;
  localparam int CTL_W     = CTL_SWCH0 + 1;
  localparam int FLAG_W    = NUM_IN + 1;
  localparam int CMP_BIT   = NUM_IN;

  logic [MODE_W-1:0] mode_q;
  logic [CTL_W-1:0]  ctrl_q;
  logic [FLAG_W-1:0] flags_q, arm_q, set_vec, clr_vec;
  logic [NUM_IN-1:0] det_vec, gated;
  logic              tick_a, tick_b, tick_c, cmp_hit;
  logic              wr_mode, wr_ctrl, wr_flags, rd_flags;
  logic              unused_wbits;

  assign unused_wbits = ^cfg_wdata[DATA_W-1:CTL_W];

  shg_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b), .tick_c(tick_c)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    shg_fault_det #(.RUN_LEN(RUN_LEN)) u_det (
      .clk(clk), .rst(rst), .pin_n(fault_n[i]),
      .mode(det_mode_e'(mode_q[2*i +: 2])),
      .tick_a(tick_a), .tick_b(tick_b), .tick_c(tick_c),
      .det(det_vec[i])
    );
  end

  shg_pair_cmp #(.NUM_PAIRS(NUM_PAIRS)) u_cmp (
    .clk(clk), .rst(rst), .pwm(pwm_mon),
    .pol(ctrl_q[CTL_POL +: NUM_PAIRS]),
    .en(ctrl_q[CTL_CMPEN]),
    .hit(cmp_hit)
  );

  assign wr_mode  = cfg_we && (cfg_addr == ADDR_MODE);
  assign wr_ctrl  = cfg_we && (cfg_addr == ADDR_CTRL);
  assign wr_flags = cfg_we && (cfg_addr == ADDR_FLAGS);
  assign rd_flags = cfg_re && (cfg_addr == ADDR_FLAGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_mode) mode_q <= cfg_wdata[MODE_W-1:0];
      if (wr_ctrl) ctrl_q <= cfg_wdata[CTL_W-1:0];
    end
  end

  // Sticky flags: clear needs a prior read that saw the bit set; set wins.
  assign set_vec = {cmp_hit, det_vec};
  assign clr_vec = wr_flags ? (arm_q & ~cfg_wdata[FLAG_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      arm_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      if (wr_flags)      arm_q <= '0;
      else if (rd_flags) arm_q <= flags_q;
    end
  end

  assign gated = flags_q[NUM_IN-1:0] & ctrl_q[NUM_IN-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hiz_hca   <= 1'b0;
      hiz_hcb   <= 1'b0;
      hiz_ch0   <= 1'b0;
      irq_fault <= 1'b0;
      irq_short <= 1'b0;
    end else begin
      hiz_hca   <= (|(gated & GRP_A_MASK)) || flags_q[CMP_BIT] || ctrl_q[CTL_SWHC];
      hiz_hcb   <= (|(gated & GRP_B_MASK)) || flags_q[CMP_BIT] || ctrl_q[CTL_SWHC];
      hiz_ch0   <= (|(gated & GRP_C_MASK)) || ctrl_q[CTL_SWCH0];
      irq_fault <= ctrl_q[CTL_IEI] && (|flags_q[NUM_IN-1:0]);
      irq_short <= ctrl_q[CTL_IEC] && flags_q[CMP_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_re) begin
      case (cfg_addr)
        ADDR_MODE:  cfg_rdata <= DATA_W'(mode_q);
        ADDR_CTRL:  cfg_rdata <= DATA_W'(ctrl_q);
        ADDR_FLAGS: cfg_rdata <= DATA_W'(flags_q);
        default:    cfg_rdata <= '0;
      endcase
    end
  end

  AST_GROUP_A_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (|(gated & GRP_A_MASK)) |=> hiz_hca); // R5

  AST_SHORT_FORCES_HC: assert property (@(posedge clk) disable iff (rst)
    flags_q[CMP_BIT] |=> hiz_hca && hiz_hcb); // R6

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !wr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R7

  AST_SW_CH0_FORCE: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CTL_SWCH0] |=> hiz_ch0); // R8

  AST_IRQ_FAULT_RAISE: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CTL_IEI] && (|flags_q[NUM_IN-1:0]) |=> irq_fault); // R9

endmodule

// File: tb/sim_shutdown_guard.sv
module sim_shutdown_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  fault_n = 9'h1FF;
  logic [5:0]  pwm_mon = 6'h00;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        hiz_hca, hiz_hcb, hiz_ch0, irq_fault, irq_short;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_MODE = 2'd0, A_CTRL = 2'd1, A_FLAGS = 2'd2;
  localparam logic [31:0] EN_ALL = 32'h1FF;
  localparam logic [31:0] C_IEI  = 32'h1 << 9;
  localparam logic [31:0] C_IEC  = 32'h1 << 10;
  localparam logic [31:0] C_CMP  = 32'h1 << 14;
  localparam logic [31:0] C_SWHC = 32'h1 << 15;
  localparam logic [31:0] C_SWC0 = 32'h1 << 16;

  // {polarity[2:0], pwm[5:0], expected short}
  localparam logic [9:0] CMP_VEC [9] = '{
    {3'b111, 6'b000011, 1'b1},
    {3'b111, 6'b000001, 1'b0},
    {3'b111, 6'b001100, 1'b1},
    {3'b111, 6'b000110, 1'b0},
    {3'b111, 6'b110000, 1'b1},
    {3'b000, 6'b111100, 1'b1},
    {3'b000, 6'b010101, 1'b0},
    {3'b101, 6'b000000, 1'b1},
    {3'b101, 6'b101001, 1'b0}
  };

  shutdown_guard u0 (
    .clk(clk), .rst(rst), .fault_n(fault_n), .pwm_mon(pwm_mon),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .hiz_hca(hiz_hca), .hiz_hcb(hiz_hcb), .hiz_ch0(hiz_ch0),
    .irq_fault(irq_fault), .irq_short(irq_short)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic clear_all();
    logic [31:0] tmp;
    rd(A_FLAGS, tmp);
    wr(A_FLAGS, 32'h0);
  endtask

  function automatic logic pick(input int g);
    case (g)
      0:       return hiz_hca;
      1:       return hiz_hcb;
      default: return hiz_ch0;
    endcase
  endfunction

  // Level-mode run on input idx with divide d, observed on group g.
  task automatic level_run(input int idx, input int d, input int g, input string tag);
    fault_n[idx] = 1'b0;
    step(3 + 15 * d);
    chk({tag, " still low before 15 full periods"}, 32'(pick(g)), 32'h0);
    step(d);
    chk({tag, " high by 16 full periods"}, 32'(pick(g)), 32'h1);
    fault_n[idx] = 1'b1;
    step(2 * d);
    clear_all();
    step(1);
    chk({tag, " released after clear"}, 32'(pick(g)), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    step(4);
    rst = 1'b0;
    step(1);

    // R1 reset state
    chk("R1 hiz_hca", 32'(hiz_hca), 0);
    chk("R1 hiz_hcb", 32'(hiz_hcb), 0);
    chk("R1 hiz_ch0", 32'(hiz_ch0), 0);
    chk("R1 irqs", {30'h0, irq_fault, irq_short}, 0);
    rd(A_FLAGS, v); chk("R1 flags", v, 0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_MODE, v);  chk("R1 mode", v, 0);

    // R6 comparator table
    foreach (CMP_VEC[n]) begin
      logic [2:0] pol;
      logic [5:0] safe;
      pol = CMP_VEC[n][9:7];
      for (int k = 0; k < 3; k++) safe[2*k +: 2] = pol[k] ? 2'b00 : 2'b11;
      pwm_mon = safe;
      wr(A_CTRL, C_IEC | C_CMP | (32'(pol) << 11));
      pwm_mon = CMP_VEC[n][6:1];
      step(2);
      chk($sformatf("R6 vec%0d not yet", n), 32'(hiz_hca), 0);
      step(1);
      chk($sformatf("R6 vec%0d hca", n), 32'(hiz_hca), 32'(CMP_VEC[n][0]));
      chk($sformatf("R6 vec%0d hcb", n), 32'(hiz_hcb), 32'(CMP_VEC[n][0]));
      chk($sformatf("R9 vec%0d irq_short", n), 32'(irq_short), 32'(CMP_VEC[n][0]));
      pwm_mon = safe;
      step(2);
      clear_all();
      step(1);
      chk($sformatf("R7 vec%0d cleared", n), 32'(hiz_hca), 0);
    end
    // R6 comparator disabled
    pwm_mon = 6'b000000;
    wr(A_CTRL, 32'h7 << 11);
    pwm_mon = 6'b000011;
    step(4);
    chk("R6 comparator off", 32'(hiz_hca), 0);
    pwm_mon = 6'b000000;

    // R10 readback
    wr(A_MODE, 32'h2A5C3);
    rd(A_MODE, v); chk("R10 mode readback", v, 32'h2A5C3);
    wr(A_CTRL, 32'h7A5);
    rd(A_CTRL, v); chk("R10 ctrl readback", v, 32'h7A5);
    wr(A_MODE, 0);
    wr(A_CTRL, 0);
    step(2);

    // R8 software force
    wr(A_CTRL, C_SWHC);
    chk("R8 hca one cycle later", 32'(hiz_hca), 0);
    step(1);
    chk("R8 hca forced", 32'(hiz_hca), 1);
    chk("R8 hcb forced", 32'(hiz_hcb), 1);
    chk("R8 ch0 untouched", 32'(hiz_ch0), 0);
    wr(A_CTRL, C_SWC0);
    step(1);
    chk("R8 hca released", 32'(hiz_hca), 0);
    chk("R8 ch0 forced", 32'(hiz_ch0), 1);
    wr(A_CTRL, 0);
    step(1);
    chk("R8 ch0 released", 32'(hiz_ch0), 0);

    // R4 edge detect on input 0
    wr(A_CTRL, EN_ALL | C_IEI);
    fault_n[0] = 1'b0;
    step(3);
    chk("R4 hca not before edge 4", 32'(hiz_hca), 0);
    chk("R4 irq not before edge 4", 32'(irq_fault), 0);
    step(1);
    chk("R4 hca at edge 4", 32'(hiz_hca), 1);
    chk("R9 irq_fault at edge 4", 32'(irq_fault), 1);
    chk("R5 hcb unaffected", 32'(hiz_hcb), 0);
    chk("R5 ch0 unaffected", 32'(hiz_ch0), 0);

    // R7 clear protocol
    wr(A_FLAGS, 0);
    step(2);
    chk("R7 write0 without read ignored", 32'(hiz_hca), 1);
    rd(A_FLAGS, v); chk("R7 flag readback", v, 32'h1);
    wr(A_FLAGS, 32'h1);
    step(2);
    chk("R7 write1 ignored", 32'(hiz_hca), 1);
    clear_all();
    chk("R7 hca one cycle after clear", 32'(hiz_hca), 1);
    step(1);
    chk("R7 hca released", 32'(hiz_hca), 0);
    chk("R9 irq released", 32'(irq_fault), 0);
    step(10);
    rd(A_FLAGS, v); chk("R4 held low no retrigger", v, 0);
    fault_n[0] = 1'b1;
    step(4);

    // R5/R7 two contributors in group A
    fault_n[1] = 1'b0; fault_n[2] = 1'b0;
    step(5);
    chk("R5 hca two inputs", 32'(hiz_hca), 1);
    rd(A_FLAGS, v); chk("R5 two flags", v, 32'h6);
    wr(A_FLAGS, 32'h4);
    step(2);
    chk("R7 hca held by remaining flag", 32'(hiz_hca), 1);
    rd(A_FLAGS, v); chk("R7 partial clear", v, 32'h4);
    wr(A_FLAGS, 0);
    step(1);
    chk("R7 hca released last flag", 32'(hiz_hca), 0);
    fault_n[1] = 1'b1; fault_n[2] = 1'b1;
    step(4);

    // R5 gating, R9 interrupt enable off
    wr(A_CTRL, EN_ALL & ~32'h20);
    fault_n[5] = 1'b0;
    step(6);
    chk("R5 gated input no hcb", 32'(hiz_hcb), 0);
    chk("R9 irq off while disabled", 32'(irq_fault), 0);
    rd(A_FLAGS, v); chk("R5 flag sets while gated", v, 32'h20);
    wr(A_CTRL, EN_ALL);
    step(1);
    chk("R5 hcb after enable", 32'(hiz_hcb), 1);
    chk("R5 hca stays off", 32'(hiz_hca), 0);
    wr(A_CTRL, EN_ALL | C_IEI);
    step(1);
    chk("R9 irq after enable", 32'(irq_fault), 1);
    fault_n[5] = 1'b1;
    clear_all();
    step(1);
    chk("R7 hcb released", 32'(hiz_hcb), 0);
    fault_n[8] = 1'b0;
    step(4);
    chk("R5 ch0 from input 8", 32'(hiz_ch0), 1);
    chk("R5 hca not from input 8", 32'(hiz_hca), 0);
    fault_n[8] = 1'b1;
    clear_all();
    step(1);
    chk("R5 ch0 released", 32'(hiz_ch0), 0);

    // R2/R3 sampling modes: in3 /8, in6 /16, in8 /128
    wr(A_MODE, 32'h32040);
    step(4);
    begin
      logic seen;
      seen = 1'b0;
      fault_n[3] = 1'b0;
      for (int c = 0; c < 120; c++) begin step(1); seen |= hiz_hca; end
      fault_n[3] = 1'b1;
      for (int c = 0; c < 24; c++) begin step(1); seen |= hiz_hca; end
      chk("R3 15-period low pulse ignored", 32'(seen), 0);
    end
    level_run(3, 8, 0, "R3 div8");
    level_run(6, 16, 1, "R2 div16");
    level_run(8, 128, 2, "R2 div128");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule